// File: doc/BRIEF.md
# PHY Management Register Bridge

The bridge gives a host one 32-bit register through which it reads and writes the registers of a single Ethernet PHY over the two-wire management interface (MDC clock, MDIO data). The host writes a 5-bit PHY register number, a direction flag and, for a write, a 16-bit value. The bridge then shifts a clause-22 management frame out on MDIO, clocked by a divided-down MDC. When the frame is finished it reports completion through the same flag bit.

The flag has opposite meanings in the two directions. To write, the host sets the flag to 1, and the bridge clears it to 0 when the frame has gone out. To read, the host writes the flag as 0, and the bridge sets it to 1 at the same moment that the captured PHY data appears in the low 16 bits. The PHY address field in every frame is fixed at 1. A host write that arrives while a frame is in flight is dropped. MDC idles low between transactions.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: The register reads as {flag at bit 31, zeros in bits 30:21, register number in bits 20:16, data in bits 15:0}, and after a completed write it holds the register number and the data that were written.
- R2: A host write with bit 31 = 1 emits the 64-bit frame: 32 ones, start 01, opcode 01, PHY address 00001, the register number MSB first, turnaround 10, then bits 15:0 MSB first. The flag reads 1 from the cycle after the request until the frame ends, and 0 afterwards.
- R3: A host write with bit 31 = 0 emits 32 ones, 01, opcode 10, 00001 and the register number. The bridge then holds mdio_oe low for the two turnaround bits and the 16 data bits. It captures mdio_i MSB first on the rising MDC edges of the 16 data bits, and then sets the flag to 1 and places the captured value in bits 15:0.
- R4: The PHY address field of every frame is 00001, whatever the host supplies.
- R5: MDC is low while idle. Each high phase and each low phase inside a frame lasts HALF_DIV system clocks. mdio_o changes only while MDC is low.
- R6: A host write while a frame is in flight is ignored: the flag, the register number and the frame on the wire are unchanged.
- R7: A transaction completes within 128*HALF_DIV+4 system clocks of the request.
- R8: After reset the register reads 0, MDC is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | One-cycle host write strobe for the access register |
| host_wr_data | input | 32 | Host write value (flag, register number, data) |
| host_rd_data | output | 32 | Current access register value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o; low releases the line |
| mdio_i | input | 1 | Management data sampled from the line |

## Verification
The bench plays the PHY. It checks every frame bit by bit at the rising MDC edges, including the fixed PHY address and the turnaround pattern. A bridge that kept driving during a read turnaround, or that captured the data on the wrong edge or off by one bit, would show up as an oe mismatch or as shifted read data. Host writes are issued in the middle of frames in both directions. A bridge that accepted them would corrupt the frame on the wire or the register number that reads back. The bench also measures every MDC phase and the time to completion, and it watches whether mdio_o ever changes while MDC is high.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam logic [4:0] PHY_ADDR = 5'd1;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef struct packed {
    logic        flag;
    logic [4:0]  regnum;
    logic [15:0] data;
  } acc_reg_t;
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = en && (cnt == LAST);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5: clock parks low whenever the engine is idle
  assert_mdc_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        req_read,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  input  logic        mdc,
  input  logic        mdc_rise,
  input  logic        mdc_fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic [15:0] rdata,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] frame_new;
  logic [FRAME_BITS-1:0] shreg;
  logic [IW-1:0]         idx;
  logic [IW-1:0]         nidx;
  logic                  is_rd;

  assign frame_new = {32'hFFFF_FFFF, 2'b01,
                      req_read ? OP_READ : OP_WRITE,
                      PHY_ADDR, req_reg,
                      req_read ? 2'b11 : 2'b10,
                      req_read ? 16'hFFFF : req_wdata};
  assign nidx = idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        is_rd   <= req_read;
        idx     <= '0;
        mdio_o  <= frame_new[FRAME_BITS-1];
        shreg   <= {frame_new[FRAME_BITS-2:0], 1'b0};
        mdio_oe <= 1'b1;
      end else if (active) begin
        if (mdc_rise && is_rd && (idx >= IW'(DATA_POS)))
          rdata <= {rdata[14:0], mdio_i};
        if (mdc_fall) begin
          if (idx == LAST_BIT) begin
            active  <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
          end else begin
            idx     <= nidx;
            mdio_o  <= shreg[FRAME_BITS-1];
            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            mdio_oe <= !(is_rd && (nidx >= IW'(TA_POS)));
          end
        end
      end
    end
  end

  // R5: data launches only while the management clock is low
  assert_mdio_change_low_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);
  // R3: line released from turnaround to the end of a read frame
  assert_read_release_R3: assert property (@(posedge clk) disable iff (rst)
    (active && is_rd && (idx >= IW'(TA_POS))) |-> !mdio_oe);
  // R7: done is a single-cycle pulse that closes a frame
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !active && $past(active));
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import phy_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr_en,
  input  logic [31:0] host_wr_data,
  output logic [31:0] host_rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int TXN_LIMIT = 2 * FRAME_BITS * HALF_DIV + 4;
  localparam int TW = $clog2(TXN_LIMIT + 1);

  acc_reg_t    acc;
  logic        busy;
  logic        is_rd;
  logic        start;
  logic        eng_active;
  logic        eng_done;
  logic [15:0] eng_rdata;
  logic        mdc_rise;
  logic        mdc_fall;
  logic        unused_hi_bits;

  assign unused_hi_bits = ^host_wr_data[30:21];
  assign start = host_wr_en && !busy;
  assign host_rd_data = {acc.flag, 10'd0, acc.regnum, acc.data};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      busy  <= 1'b0;
      is_rd <= 1'b0;
    end else if (start) begin
      acc.flag   <= host_wr_data[31];
      acc.regnum <= host_wr_data[20:16];
      acc.data   <= host_wr_data[15:0];
      is_rd      <= !host_wr_data[31];
      busy       <= 1'b1;
    end else if (eng_done) begin
      busy     <= 1'b0;
      acc.flag <= is_rd;
      if (is_rd) acc.data <= eng_rdata;
    end
  end

  mdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .en   (eng_active),
    .mdc  (mdc),
    .rise (mdc_rise),
    .fall (mdc_fall)
  );

  mdio_frame_engine u_engine (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .req_read  (!host_wr_data[31]),
    .req_reg   (host_wr_data[20:16]),
    .req_wdata (host_wr_data[15:0]),
    .mdc       (mdc),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .done      (eng_done),
    .rdata     (eng_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  logic [TW-1:0] txn_cycles;
  always_ff @(posedge clk) begin
    if (rst || !busy) txn_cycles <= '0;
    else              txn_cycles <= txn_cycles + 1'b1;
  end

  // R6: a request during a frame leaves register number and flag alone
  assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr_en && !eng_done) |=> (acc.regnum == $past(acc.regnum)) && (acc.flag == $past(acc.flag)));
  // R2: a finished write reports with flag low
  assert_write_flag_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !is_rd) |=> !host_rd_data[31]);
  // R3: a finished read reports with flag high
  assert_read_flag_set_R3: assert property (@(posedge clk) disable iff (rst)
    (eng_done && is_rd) |=> host_rd_data[31]);
  // R7: bounded transaction time
  assert_txn_bound_R7: assert property (@(posedge clk) disable iff (rst)
    txn_cycles <= TW'(TXN_LIMIT));
endmodule

// File: tb/phy_mgmt_bridge_tb.sv
module phy_mgmt_bridge_tb_top;
  localparam int H = 4;
  localparam int LIMIT = 128 * H + 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  phy_mgmt_bridge #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  typedef struct { logic [63:0] bits; bit rd; } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // PHY model: response word and bit counter
  logic [15:0] phy_resp = 16'h0000;
  int          bitcnt = 0;
  assign mdio_i = (bitcnt >= 48 && bitcnt < 64) ? phy_resp[63 - bitcnt] : 1'b1;

  // Monitor: collects frame bits at MDC rising, checks phases
  logic [63:0] got_bits;
  logic [63:0] got_oe;
  logic        mdc_q = 1'b0;
  logic        mo_q = 1'b0;
  int          since_t = 0;
  always @(negedge clk) begin
    if (!rst) begin
      since_t++;
      if (mdio_o !== mo_q && mdc)
        check(1'b0, "R5 mdio_o changed while mdc high", {63'd0, mdio_o}, {63'd0, mo_q});
      if (mdc && !mdc_q) begin
        if (bitcnt > 0) check(since_t == H, "R5 low phase", 64'(since_t), 64'(H));
        since_t = 0;
        got_bits[63 - bitcnt] = mdio_o;
        got_oe[63 - bitcnt]   = mdio_oe;
        bitcnt++;
        if (bitcnt == 64) begin
          exp_t e;
          bitcnt = 0;
          if (exp_q.size() == 0) check(1'b0, "R2 unexpected frame", got_bits, 64'd0);
          else begin
            logic [63:0] emask, eoe;
            e = exp_q.pop_front();
            emask = e.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
            eoe   = e.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
            check((got_bits & emask) == (e.bits & emask),
                  e.rd ? "R3 R4 read frame bits" : "R2 R4 write frame bits", got_bits, e.bits);
            check(got_oe == eoe, e.rd ? "R3 oe release" : "R2 oe drive", got_oe, eoe);
          end
        end
      end else if (!mdc && mdc_q) begin
        check(since_t == H, "R5 high phase", 64'(since_t), 64'(H));
        since_t = 0;
      end
      mdc_q = mdc;
      mo_q  = mdio_o;
    end
  end

  task automatic host_write(input logic [31:0] v);
    @(negedge clk);
    host_wr_data = v;
    host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic push_exp(input bit rd, input logic [4:0] r, input logic [15:0] d);
    exp_t e;
    e.rd = rd;
    e.bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, 5'd1, r, rd ? 2'b00 : 2'b10, rd ? 16'h0 : d};
    exp_q.push_back(e);
  endtask

  task automatic wait_flag(input logic want, input string req);
    int n = 0;
    while (host_rd_data[31] !== want && n < LIMIT + 10) begin
      @(negedge clk);
      n++;
    end
    check(n <= LIMIT, req, 64'(n), 64'(LIMIT));
  endtask

  task automatic do_write(input logic [4:0] r, input logic [15:0] d, input int intrude);
    push_exp(1'b0, r, d);
    host_write({1'b1, 10'd0, r, d});
    check(host_rd_data[31] === 1'b1, "R2 flag set during write", {63'd0, host_rd_data[31]}, 64'd1);
    if (intrude > 0) begin
      repeat (intrude) @(negedge clk);
      host_write({1'b0, 10'h3FF, ~r, ~d});
      check(host_rd_data === {1'b1, 10'd0, r, d}, "R6 ignored during write",
            64'(host_rd_data), 64'({1'b1, 10'd0, r, d}));
    end
    wait_flag(1'b0, "R7 write completion time");
    check(host_rd_data === {11'd0, r, d}, "R1 R2 register after write",
          64'(host_rd_data), 64'({11'd0, r, d}));
  endtask

  task automatic do_read(input logic [4:0] r, input logic [15:0] resp, input int intrude);
    phy_resp = resp;
    push_exp(1'b1, r, 16'h0);
    host_write({1'b0, 10'd0, r, 16'hDEAD});
    check(host_rd_data[31] === 1'b0, "R3 flag low during read", {63'd0, host_rd_data[31]}, 64'd0);
    if (intrude > 0) begin
      repeat (intrude) @(negedge clk);
      host_write({1'b1, 10'd0, ~r, 16'h5555});
      check(host_rd_data[31:16] === {11'd0, r}, "R6 ignored during read",
            64'(host_rd_data[31:16]), 64'({11'd0, r}));
    end
    wait_flag(1'b1, "R7 read completion time");
    check(host_rd_data === {1'b1, 10'd0, r, resp}, "R3 read data and flag",
          64'(host_rd_data), 64'({1'b1, 10'd0, r, resp}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(host_rd_data === 32'd0, "R8 R1 reset register", 64'(host_rd_data), 64'd0);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R8 reset pins", {62'd0, mdc, mdio_oe}, 64'd0);

    do_write(5'h00, 16'hA5C3, 0);
    do_write(5'h1F, 16'hFFFF, 0);
    do_read (5'h02, 16'h1234, 0);
    do_read (5'h11, 16'h8001, 0);
    do_write(5'h03, 16'h0F0F, 40);
    do_read (5'h1A, 16'hC3A5, 300);
    do_write(5'h15, 16'h0001, 0);
    repeat (20) @(negedge clk);
    check(mdc === 1'b0, "R5 mdc idle low", {63'd0, mdc}, 64'd0);
    check(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule